// File: doc/BRIEF.md
# Motor Configuration Register Bank

This block holds one 8-bit setup word for each of five motors. A host or a panel of switches
writes the words through a plain address, data and write-enable port. The address is four bits
wide, although only five locations exist. Each stored word is split into the per-motor
controls: a run enable, a direction, a brake and a 5-bit PWM high time. A motor PWM stage
downstream can use these fields without further decoding.

The address decoder drives a separate write strobe for each register, so a write can change
only the register it names. Codes 5 to 15 are rejected. For those codes no register strobe
rises, and the data routed towards the registers is forced to zero. The stored enable bit of
each motor is ANDed with a global run button before it leaves the block. The block also
reports, as a one-hot vector, which register took the most recent write.

Top module: `motor_cfg_bank`

## Requirements
- R1: While `rst` is high on a rising clock edge, all five registers clear to zero. From the next cycle `mot_run`, `mot_dir`, `mot_brk`, `mot_high` and `wr_strobe` all read zero.
- R2: With `wr_en` high and `addr` from 0 to 4 on a rising edge, the word on `wdata` is stored in the register for motor `addr` (address 0 is motor 0, address 4 is motor 4). Its fields appear on the outputs after that edge.
- R3: A write changes only the addressed register. The fields of the other four motors keep their values.
- R4: A write with `addr` from 5 to 15 changes no register, and `wr_strobe` stays all zero in the following cycle.
- R5: When `wr_en` is low, no register changes, whatever `addr` and `wdata` carry.
- R6: Field layout of a word: bit 7 is the motor enable, bit 6 the direction (`mot_dir`), bit 5 the brake (`mot_brk`), and bits 4..0 the high time. Motor i uses bits 5i+4..5i of `mot_high`.
- R7: `mot_run[i]` is motor i's stored enable bit ANDed with `run_btn`. With `run_btn` low, every bit of `mot_run` is low.
- R8: In the cycle after an accepted write, `wr_strobe` has exactly the bit of the written register set. In a cycle with no accepted write it is all zero, so a single write gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register select; codes 0 to 4 are valid |
| wdata | input | 8 | Configuration word to store |
| wr_en | input | 1 | Write request for the current cycle |
| run_btn | input | 1 | Global run button, gates every motor enable |
| mot_run | output | 5 | Per-motor effective run enable |
| mot_dir | output | 5 | Per-motor direction bit |
| mot_brk | output | 5 | Per-motor brake bit |
| mot_high | output | 25 | Per-motor 5-bit PWM high time, packed |
| wr_strobe | output | 5 | One-hot marker of the register written on the previous edge |

## Verification
The bench builds the block with its default parameters: five motors and a 4-bit address. Every
address code is therefore reachable, including the out-of-range codes 5, 9 and 15. It writes
field patterns that separate the enable, direction, brake and high-time bits. It overwrites a
single register to show that the other registers keep their values, and it toggles the run
button while all motors are enabled.

// File: rtl/motor_cfg_pkg.sv
package motor_cfg_pkg;

    localparam int CFG_HIGH_W = 5;
    localparam int CFG_WORD_W = CFG_HIGH_W + 3;

    typedef struct packed {
        logic                  enable;
        logic                  dir;
        logic                  brake;
        logic [CFG_HIGH_W-1:0] high_time;
    } cfg_word_t;

    function automatic cfg_word_t unpack_word(input logic [CFG_WORD_W-1:0] raw);
        cfg_word_t w;
        w.enable    = raw[CFG_WORD_W-1];
        w.dir       = raw[CFG_WORD_W-2];
        w.brake     = raw[CFG_WORD_W-3];
        w.high_time = raw[CFG_HIGH_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import motor_cfg_pkg::*;
#(
    parameter int NUM_MOTORS = 5,
    parameter int ADDR_W     = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CFG_WORD_W-1:0] wdata,
    input  logic                  wr_en,
    output logic [NUM_MOTORS-1:0] sel,
    output logic [CFG_WORD_W-1:0] routed
);
    logic in_range;

    assign in_range = ({1'b0, addr} < (ADDR_W+1)'(NUM_MOTORS));
    assign routed   = in_range ? wdata : '0;

    for (genvar i = 0; i < NUM_MOTORS; i++) begin : g_sel
        assign sel[i] = wr_en && in_range && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/cfg_word_reg.sv
module cfg_word_reg
    import motor_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CFG_WORD_W-1:0] d,
    output cfg_word_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= unpack_word(d);
        end
    end
endmodule

// File: rtl/motor_cfg_bank.sv
module motor_cfg_bank
    import motor_cfg_pkg::*;
#(
    parameter int NUM_MOTORS = 5,
    parameter int ADDR_W     = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [CFG_WORD_W-1:0]            wdata,
    input  logic                             wr_en,
    input  logic                             run_btn,
    output logic [NUM_MOTORS-1:0]            mot_run,
    output logic [NUM_MOTORS-1:0]            mot_dir,
    output logic [NUM_MOTORS-1:0]            mot_brk,
    output logic [NUM_MOTORS*CFG_HIGH_W-1:0] mot_high,
    output logic [NUM_MOTORS-1:0]            wr_strobe
);
    logic [NUM_MOTORS-1:0] sel;
    logic [CFG_WORD_W-1:0] routed;
    cfg_word_t             words [NUM_MOTORS];

    cfg_addr_decode #(
        .NUM_MOTORS(NUM_MOTORS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .sel   (sel),
        .routed(routed)
    );

    for (genvar i = 0; i < NUM_MOTORS; i++) begin : g_motor
        cfg_word_reg u_reg (
            .clk(clk),
            .rst(rst),
            .we (sel[i]),
            .d  (routed),
            .q  (words[i])
        );
        assign mot_run[i] = words[i].enable & run_btn;
        assign mot_dir[i] = words[i].dir;
        assign mot_brk[i] = words[i].brake;
        assign mot_high[i*CFG_HIGH_W +: CFG_HIGH_W] = words[i].high_time;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_strobe <= '0;
        end else begin
            wr_strobe <= sel;
        end
    end
endmodule

// File: rtl/motor_cfg_bank_chk.sv
module motor_cfg_bank_chk
    import motor_cfg_pkg::*;
#(
    parameter int NUM_MOTORS = 5,
    parameter int ADDR_W     = 4
) (
    input logic                             clk,
    input logic                             rst,
    input logic [ADDR_W-1:0]                addr,
    input logic                             wr_en,
    input logic                             run_btn,
    input logic [NUM_MOTORS-1:0]            mot_run,
    input logic [NUM_MOTORS-1:0]            mot_dir,
    input logic [NUM_MOTORS-1:0]            mot_brk,
    input logic [NUM_MOTORS*CFG_HIGH_W-1:0] mot_high,
    input logic [NUM_MOTORS-1:0]            wr_strobe
);
    logic addr_ok;
    assign addr_ok = ({1'b0, addr} < (ADDR_W+1)'(NUM_MOTORS));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (wr_strobe == '0 && mot_high == '0 && mot_dir == '0 && mot_brk == '0));

    assert_strobe_target_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_ok) |=> (wr_strobe == (NUM_MOTORS'(1) << $past(addr))));

    assert_oob_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_ok) |=> (wr_strobe == '0 && $stable(mot_high) && $stable(mot_dir)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mot_high) && $stable(mot_dir) && $stable(mot_brk)));

    assert_run_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !run_btn |-> (mot_run == '0));

    assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_strobe));
endmodule

bind motor_cfg_bank motor_cfg_bank_chk #(
    .NUM_MOTORS(NUM_MOTORS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .run_btn  (run_btn),
    .mot_run  (mot_run),
    .mot_dir  (mot_dir),
    .mot_brk  (mot_brk),
    .mot_high (mot_high),
    .wr_strobe(wr_strobe)
);

// File: tb/test_motor_cfg_bank.sv
module test_motor_cfg_bank;
    localparam int N  = 5;
    localparam int AW = 4;
    localparam int HW = 5;

    typedef struct packed {
        logic [N-1:0]    strobe;
        logic [N-1:0]    run;
        logic [N-1:0]    dir;
        logic [N-1:0]    brk;
        logic [N*HW-1:0] high;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_en = 1'b0;
    logic          run_btn = 1'b0;
    logic [N-1:0]  mot_run, mot_dir, mot_brk, wr_strobe;
    logic [N*HW-1:0] mot_high;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [7:0] mdl [N];
    bit   done = 1'b0;

    always #5 clk = ~clk;

    motor_cfg_bank #(.NUM_MOTORS(N), .ADDR_W(AW)) i_motor_cfg_bank (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .run_btn(run_btn), .mot_run(mot_run), .mot_dir(mot_dir), .mot_brk(mot_brk),
        .mot_high(mot_high), .wr_strobe(wr_strobe)
    );

    task automatic step(input logic r, input logic we, input logic [AW-1:0] a,
                        input logic [7:0] d, input logic rb, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = we; addr = a; wdata = d; run_btn = rb;
        e.strobe = '0;
        if (r) begin
            for (int i = 0; i < N; i++) mdl[i] = 8'h00;
        end else if (we && a < N) begin
            mdl[a] = d;
            e.strobe[a] = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            e.run[i] = mdl[i][7] & rb;
            e.dir[i] = mdl[i][6];
            e.brk[i] = mdl[i][5];
            e.high[i*HW +: HW] = mdl[i][4:0];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected item per clock, after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                exp_t  got;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = '{wr_strobe, mot_run, mot_dir, mot_brk, mot_high};
                n_tests++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s: strobe/run/dir/brk/high got %b/%b/%b/%b/%h expected %b/%b/%b/%b/%h",
                             t, got.strobe, got.run, got.dir, got.brk, got.high,
                             e.strobe, e.run, e.dir, e.brk, e.high);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = 8'h00;
        repeat (2) @(posedge clk);
        // R1: reset state
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b1, "R1 reset state");
        // R2 / R6: fill every register with distinct field patterns
        step(1'b0, 1'b1, 4'd0, 8'h93, 1'b1, "R2 write motor0");
        step(1'b0, 1'b1, 4'd1, 8'hC1, 1'b1, "R2 R6 write motor1 en+dir");
        step(1'b0, 1'b1, 4'd2, 8'hA4, 1'b1, "R6 write motor2 en+brake");
        step(1'b0, 1'b1, 4'd3, 8'h7F, 1'b1, "R6 write motor3 dir+brake no enable");
        step(1'b0, 1'b1, 4'd4, 8'h14, 1'b1, "R2 write motor4");
        // R8: strobe drops after the write
        step(1'b0, 1'b0, 4'd4, 8'h00, 1'b1, "R8 strobe back to zero");
        // R5: idle cycles with live address and data
        step(1'b0, 1'b0, 4'd2, 8'hFF, 1'b1, "R5 wr_en low ignored");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, "R5 wr_en low ignored again");
        // R3: overwrite one register only
        step(1'b0, 1'b1, 4'd2, 8'h4A, 1'b1, "R3 overwrite motor2 only");
        step(1'b0, 1'b1, 4'd0, 8'hE0, 1'b1, "R3 overwrite motor0 only");
        // R4: out-of-range codes
        step(1'b0, 1'b1, 4'd5, 8'hFF, 1'b1, "R4 address 5 rejected");
        step(1'b0, 1'b1, 4'd9, 8'hFF, 1'b1, "R4 address 9 rejected");
        step(1'b0, 1'b1, 4'd15, 8'hFF, 1'b1, "R4 address 15 rejected");
        // R7: run button gating
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, AW'(i), 8'h80 | 8'(i), 1'b1, "R7 enable all");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, "R7 run button released");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, "R7 run button pressed");
        // R8: back-to-back writes move the strobe
        step(1'b0, 1'b1, 4'd3, 8'h1F, 1'b1, "R8 strobe motor3");
        step(1'b0, 1'b1, 4'd1, 8'h00, 1'b1, "R8 strobe motor1");
        // R1: reset in mid run
        step(1'b1, 1'b1, 4'd2, 8'hFF, 1'b1, "R1 reset wins over write");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, "R1 cleared after reset");
        @(negedge clk);
        wr_en = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule